// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Level Flags

This block is a single-clock first-in first-out buffer for 18-bit words, one bit per channel. A producer pushes words with a write enable and a consumer pops them with a read enable; the popped word appears on a registered output and stays there until the next successful pop. Four level flags report the fill state: empty, full, and two thresholds, almost-empty and almost-full, whose distances from the ends are programmable.

The offsets come from a small configuration port. Two active-low resets clear the buffer. The master reset is asynchronous and clears everything, returning the offsets to their defaults. The partial reset is sampled at the clock edge and discards the buffered words while keeping the programmed offsets. This lets a test sequence flush the buffer between runs without reprogramming the thresholds. Reads and writes take effect only while both resets are released.

Top module: `prog_flag_fifo`

## Requirements
- R1: Words leave in the order they were written. After a read is accepted at a clock edge, rd_data_o shows the oldest stored word from that edge on.
- R2: empty_o is high exactly when zero words are stored, and full_o is high exactly when DEPTH words are stored.
- R3: A write while full_o is high is ignored: it changes neither the stored count nor the contents. A read while empty_o is high is ignored: it changes neither the count nor rd_data_o.
- R4: rd_data_o holds the last word read until the next accepted read.
- R5: almost_empty_o is high exactly when the stored count is less than or equal to the almost-empty offset.
- R6: almost_full_o is high exactly when the stored count is greater than or equal to DEPTH minus the almost-full offset.
- R7: While mst_rst_ni is low (asynchronous), the buffer is empty and rd_data_o is zero. The offsets return to AE_OFF_DEF and AF_OFF_DEF, which default to 511.
- R8: A clock edge with prt_rst_ni low empties the buffer and zeroes rd_data_o, and keeps the programmed offsets. Reads and writes at such an edge are ignored.
- R9: An edge with cfg_we_i high loads both offsets, from cfg_ae_off_i and cfg_af_off_i. This applies whatever the state of prt_rst_ni, and the flags follow the new offsets from that edge on. Offsets are $clog2(DEPTH) bits wide, so they are always below DEPTH.
- R10: A read and a write at the same edge are both accepted when the buffer is neither empty nor full, which leaves the count unchanged. When the buffer is empty only the write is accepted. When it is full only the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| mst_rst_ni | input | 1 | Master reset, active low, asynchronous; clears data and offsets |
| prt_rst_ni | input | 1 | Partial reset, active low, synchronous; clears data only |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Word to write |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Last word read |
| cfg_we_i | input | 1 | Load both offsets |
| cfg_ae_off_i | input | $clog2(DEPTH) | Almost-empty offset |
| cfg_af_off_i | input | $clog2(DEPTH) | Almost-full offset |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| almost_empty_o | output | 1 | Count at or below the almost-empty offset |
| almost_full_o | output | 1 | Count at or above DEPTH minus the almost-full offset |

## Verification
The bench builds the block with DEPTH 16, AE_OFF_DEF 3 and AF_OFF_DEF 5, instead of 2048 and 511. With these values it can fill the buffer to full and drain it many times in a short run, wrap both pointers, and cross every flag threshold in both directions. A bench model tracks the queue, the last word read and the offsets, and every flag and the read data are compared on every cycle. The smaller default offsets also make it possible to tell after a master reset that the offsets went back to their defaults and did not keep the programmed values.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int unsigned DATA_W = 18;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (clr_i)  rdata_o <= '0;
    else if (re_i)   rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pff_ptr.sv
module pff_ptr #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_ok_i,
  input  logic          rd_ok_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_o <= '0;
      raddr_o <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      waddr_o <= '0;
      raddr_o <= '0;
      count_o <= '0;
    end else begin
      if (wr_ok_i) waddr_o <= (waddr_o == LAST) ? '0 : waddr_o + 1'b1;
      if (rd_ok_i) raddr_o <= (raddr_o == LAST) ? '0 : raddr_o + 1'b1;
      if (wr_ok_i && !rd_ok_i)      count_o <= count_o + 1'b1;
      else if (rd_ok_i && !wr_ok_i) count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/pff_flags.sv
module pff_flags #(
  parameter int unsigned DEPTH      = 2048,
  parameter int unsigned AE_OFF_DEF = 511,
  parameter int unsigned AF_OFF_DEF = 511,
  localparam int unsigned OW        = $clog2(DEPTH),
  localparam int unsigned CW        = OW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [OW-1:0] cfg_ae_off_i,
  input  logic [OW-1:0] cfg_af_off_i,
  input  logic [CW-1:0] count_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);
  logic [OW-1:0] ae_off_q, af_off_q;
  logic [CW-1:0] af_level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= OW'(AE_OFF_DEF);
      af_off_q <= OW'(AF_OFF_DEF);
    end else if (cfg_we_i) begin
      ae_off_q <= cfg_ae_off_i;
      af_off_q <= cfg_af_off_i;
    end
  end

  always_comb begin
    af_level       = CW'(DEPTH) - CW'(af_off_q);
    empty_o        = (count_i == '0);
    full_o         = (count_i == CW'(DEPTH));
    almost_empty_o = (count_i <= CW'(ae_off_q));
    almost_full_o  = (count_i >= af_level);
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int unsigned DW         = pff_pkg::DATA_W,
  parameter int unsigned DEPTH      = 2048,
  parameter int unsigned AE_OFF_DEF = 511,
  parameter int unsigned AF_OFF_DEF = 511,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned CW        = AW + 1
) (
  input  logic          clk_i,
  input  logic          mst_rst_ni,
  input  logic          prt_rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_ae_off_i,
  input  logic [AW-1:0] cfg_af_off_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);
  logic          clr, wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;

  assign clr   = !prt_rst_ni;
  // full blocks a write even with a read at the same edge
  assign wr_ok = prt_rst_ni && wr_en_i && !full_o;
  assign rd_ok = prt_rst_ni && rd_en_i && !empty_o;

  pff_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (mst_rst_ni),
    .clr_i   (clr),
    .wr_ok_i (wr_ok),
    .rd_ok_i (rd_ok),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .count_o (count)
  );

  pff_mem #(.DW(DW), .DEPTH(DEPTH)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (mst_rst_ni),
    .clr_i   (clr),
    .we_i    (wr_ok),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .re_i    (rd_ok),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

  pff_flags #(.DEPTH(DEPTH), .AE_OFF_DEF(AE_OFF_DEF), .AF_OFF_DEF(AF_OFF_DEF)) i_flags (
    .clk_i          (clk_i),
    .rst_ni         (mst_rst_ni),
    .cfg_we_i       (cfg_we_i),
    .cfg_ae_off_i   (cfg_ae_off_i),
    .cfg_af_off_i   (cfg_af_off_i),
    .count_i        (count),
    .empty_o        (empty_o),
    .full_o         (full_o),
    .almost_empty_o (almost_empty_o),
    .almost_full_o  (almost_full_o)
  );
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          mst_rst_ni,
  input logic          prt_rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rd_data_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          almost_empty_o,
  input logic          almost_full_o
);
  assert_flags_exclusive_R2: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    !(empty_o && full_o));

  assert_empty_in_ae_R5: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    empty_o |-> almost_empty_o);

  assert_full_in_af_R6: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    full_o |-> almost_full_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    prt_rst_ni && full_o && wr_en_i && !rd_en_i |=> full_o);

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    prt_rst_ni && empty_o && rd_en_i && !wr_en_i |=> empty_o && $stable(rd_data_o));

  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    prt_rst_ni && !rd_en_i |=> $stable(rd_data_o));

  assert_partial_clear_R8: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    !prt_rst_ni |=> empty_o && (rd_data_o == '0));

  assert_empty_rw_R10: assert property (@(posedge clk_i) disable iff (!mst_rst_ni)
    prt_rst_ni && empty_o && wr_en_i && rd_en_i |=> !empty_o && $stable(rd_data_o));
endmodule

bind prog_flag_fifo pff_checker #(.DW(DW)) i_pff_checker (
  .clk_i          (clk_i),
  .mst_rst_ni     (mst_rst_ni),
  .prt_rst_ni     (prt_rst_ni),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .rd_data_o      (rd_data_o),
  .empty_o        (empty_o),
  .full_o         (full_o),
  .almost_empty_o (almost_empty_o),
  .almost_full_o  (almost_full_o)
);

// File: tb/test_prog_flag_fifo.sv
module test_prog_flag_fifo;
  localparam int DEPTH  = 16;
  localparam int AE_DEF = 3;
  localparam int AF_DEF = 5;
  localparam int DW     = 18;
  localparam int OW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic mst_rst_n = 1'b0, prt_rst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [OW-1:0] cfg_ae = '0, cfg_af = '0;
  logic [DW-1:0] rd_data;
  logic empty, full, aempty, afull;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd = '0;
  int ae_off = AE_DEF, af_off = AF_DEF;

  always #5 clk = ~clk;

  prog_flag_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_OFF_DEF(AE_DEF), .AF_OFF_DEF(AF_DEF)) i_prog_flag_fifo (
    .clk_i(clk), .mst_rst_ni(mst_rst_n), .prt_rst_ni(prt_rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .cfg_we_i(cfg_we), .cfg_ae_off_i(cfg_ae), .cfg_af_off_i(cfg_af),
    .empty_o(empty), .full_o(full), .almost_empty_o(aempty), .almost_full_o(afull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int cnt = exp_q.size();
    chk({tag, " R2 empty"}, int'(empty), int'(cnt == 0));
    chk({tag, " R2 full"}, int'(full), int'(cnt == DEPTH));
    chk({tag, " R5 almost_empty"}, int'(aempty), int'(cnt <= ae_off));
    chk({tag, " R6 almost_full"}, int'(afull), int'(cnt >= DEPTH - af_off));
    chk({tag, " rd_data"}, int'(rd_data), int'(last_rd));
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic wr, input logic [DW-1:0] d, input logic rd, input string tag);
    bit was_full = (exp_q.size() == DEPTH);
    bit was_empty = (exp_q.size() == 0);
    wr_en = wr; wr_data = d; rd_en = rd;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (rd && !was_empty) last_rd = exp_q.pop_front();
    if (wr && !was_full) exp_q.push_back(d);
    check_all(tag);
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) step(1'b0, '0, 1'b1, tag);
  endtask

  task automatic fill_to(input int n, input int seed, input string tag);
    while (exp_q.size() < n) step(1'b1, DW'(seed * 977 + exp_q.size() * 131 + 7), 1'b0, tag);
  endtask

  task automatic t_reset;
    check_all("R7 reset state");
  endtask

  task automatic t_fill_drain;
    fill_to(DEPTH, 1, "R1 fill");
    step(1'b1, 18'h2aaaa, 1'b0, "R3 write when full");
    drain("R1 order");
    step(1'b0, '0, 1'b1, "R3 read when empty");
  endtask

  task automatic t_hold;
    step(1'b1, 18'h15555, 1'b0, "R4 wr a");
    step(1'b1, 18'h0f0f0, 1'b0, "R4 wr b");
    step(1'b0, '0, 1'b1, "R1 rd a");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, "R4 hold");
    drain("R4 drain");
  endtask

  task automatic t_simul;
    step(1'b1, 18'h11111, 1'b1, "R10 rw when empty");
    step(1'b1, 18'h22222, 1'b1, "R10 rw mid");
    fill_to(DEPTH, 2, "R10 fill");
    step(1'b1, 18'h33333, 1'b1, "R10 rw when full");
    drain("R10 drain");
  endtask

  task automatic t_cfg;
    cfg_we = 1'b1; cfg_ae = OW'(6); cfg_af = OW'(2);
    @(negedge clk);
    cfg_we = 1'b0;
    ae_off = 6; af_off = 2;
    check_all("R9 after load");
    fill_to(DEPTH, 3, "R9 fill new offsets");
    drain("R9 drain new offsets");
  endtask

  task automatic t_partial;
    fill_to(5, 4, "R8 prefill");
    prt_rst_n = 1'b0; wr_en = 1'b1; wr_data = 18'h3ffff; rd_en = 1'b1;
    @(negedge clk);
    prt_rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    exp_q.delete(); last_rd = '0;
    check_all("R8 after partial reset");
    fill_to(8, 5, "R8 offsets kept");
    drain("R8 drain");
  endtask

  task automatic t_master;
    fill_to(3, 6, "R7 prefill");
    step(1'b0, '0, 1'b1, "R7 read one");
    mst_rst_n = 1'b0;
    #1;
    chk("R7 async empty", int'(empty), 1);
    chk("R7 async rd_data", int'(rd_data), 0);
    @(negedge clk);
    mst_rst_n = 1'b1;
    exp_q.delete(); last_rd = '0; ae_off = AE_DEF; af_off = AF_DEF;
    check_all("R7 after master reset");
    fill_to(DEPTH, 7, "R7 default offsets");
    drain("R7 drain");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    mst_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_hold();
    t_simul();
    t_cfg();
    t_partial();
    t_master();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule